// File: doc/BRIEF.md
# CCM Frame Protection Controller

This block protects one packet at a time with CCM authenticated encryption. It does not hold a cipher of its own. It drives a single shared AES encryption core through a request/response pair and uses that core for two jobs. The first is the CBC-MAC chain that produces an 8-byte integrity code. The second is the counter-mode keystream that hides the payload and that code. Because the MAC chain feeds each cipher result back into the next request, the core is used strictly one block at a time.

A packet begins with a start handshake that supplies a 48-bit packet number, a 48-bit source address and the payload length in bytes. The nonce is 13 bytes: a zero priority byte, the source address, then the packet number. Payload arrives as 128-bit blocks with a last flag. For every block the controller issues one MAC request and then one keystream request, and it emits that block's ciphertext before it accepts the next block, so no packet buffer is needed. After the last block it encrypts the MIC with counter 0 and emits it as the final output beat. No header data is authenticated.

All multi-byte fields are big-endian. Byte 0 of a block sits in bits 127:120.

Top module: `ccm_engine`

## Requirements
- R1: Right after reset, start_ready is 1, and out_valid, in_ready and aes_req_valid are 0.
- R2: The first core request of a packet is the initial MAC block. Its layout is: byte 0 = 0x19, byte 1 = 0x00, bytes 2..7 = source address, bytes 8..13 = packet number, bytes 14..15 = payload length.
- R3: Payload block k is zero-padded beyond the valid bytes of the last block. Its MAC request is the previous core result XOR that padded block. The controller never issues a new request while it is waiting for a response.
- R4: Keystream requests use this layout: byte 0 = 0x01, byte 1 = 0x00, then source address, packet number and a 16-bit counter. The MAC request of block k is followed by the keystream request with counter k (counting from 1). The final request uses counter 0.
- R5: Each ciphertext beat is the padded block XOR its keystream. Its out_bytes is 16, except on the last block, where it is the payload length mod 16 (16 when that is 0). Bytes beyond out_bytes are zero.
- R6: The final beat carries the upper 8 bytes of the MAC XOR the upper 8 bytes of the counter-0 keystream, in bits 127:64. Bits 63:0 are zero, out_bytes is 8 and out_last is 1.
- R7: With a zero payload length, no input block is taken. The packet gives exactly two core requests and one output beat (the MIC).
- R8: While a valid is held against a low ready, out_data, out_bytes and aes_req_data do not change.
- R9: start_ready is 0 from the start handshake until the MIC beat is taken. Exactly one input block is accepted per payload block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Packet parameters are valid |
| start_ready | output | 1 | Controller is idle and takes a packet |
| pkt_num | input | 48 | Packet number for the nonce |
| src_addr | input | 48 | Source address for the nonce |
| pay_len | input | 16 | Payload length in bytes |
| in_valid | input | 1 | Payload block is valid |
| in_ready | output | 1 | Controller takes a payload block |
| in_data | input | 128 | Payload block, byte 0 in bits 127:120 |
| in_last | input | 1 | Marks the final payload block |
| out_valid | output | 1 | Output beat is valid |
| out_ready | input | 1 | Consumer takes the output beat |
| out_data | output | 128 | Ciphertext or encrypted MIC |
| out_bytes | output | 5 | Number of valid bytes in out_data |
| out_last | output | 1 | Beat is the encrypted MIC |
| aes_req_valid | output | 1 | Block for the cipher core is valid |
| aes_req_ready | input | 1 | Cipher core takes the block |
| aes_req_data | output | 128 | Block to encrypt |
| aes_rsp_valid | input | 1 | Cipher result is valid (one cycle) |
| aes_rsp_data | input | 128 | Cipher result |

## Verification
Most internal faults show up first on the cipher request bus, one or two requests after the fault. A wrong nonce, length field, counter value or chain register changes the block sent to the core. A wrong padding mask or keystream alignment corrupts the ciphertext beat of the same block. A corrupted MAC register stays hidden until the final MIC beat, but it is also visible earlier in the next MAC request. Sequencing faults such as a lost block, an extra request or a missing MIC show up as a wrong count of requests or output beats, or as a packet that never completes.

// File: rtl/ccm_pkg.sv
package ccm_pkg;
    parameter int BLK_W     = 128;
    parameter int PN_W      = 48;
    parameter int ADDR_W    = 48;
    parameter int LEN_W     = 16;
    parameter int CNT_W     = 16;
    parameter int MIC_BYTES = 8;

    localparam int NBYTES = BLK_W / 8;
    localparam int NB_W   = $clog2(NBYTES + 1);
    localparam int MIC_W  = MIC_BYTES * 8;
    localparam int TAIL_W = $clog2(NBYTES);

    localparam logic [7:0] B0_FLAGS  = 8'h19;
    localparam logic [7:0] CTR_FLAGS = 8'h01;

    typedef enum logic [2:0] {
        ST_IDLE, ST_MAC_FIRST, ST_MAC_DATA, ST_CTR_DATA, ST_CTR_MIC, ST_DONE
    } ctl_state_t;

    typedef enum logic [1:0] {
        PH_IN, PH_REQ, PH_WAIT, PH_OUT
    } phase_t;

    typedef struct packed {
        logic [7:0]        prio;
        logic [ADDR_W-1:0] addr;
        logic [PN_W-1:0]   pn;
    } nonce_t;

    function automatic logic [NB_W-1:0] tail_bytes(input logic [LEN_W-1:0] len);
        logic [TAIL_W-1:0] rem;
        rem = len[TAIL_W-1:0];
        return (rem == '0) ? NB_W'(NBYTES) : NB_W'(rem);
    endfunction
endpackage

// File: rtl/ccm_blkgen.sv
module ccm_blkgen
    import ccm_pkg::*;
(
    input  nonce_t             nonce,
    input  logic [LEN_W-1:0]   len,
    input  logic [CNT_W-1:0]   ctr,
    input  logic               sel_first,
    output logic [BLK_W-1:0]   blk
);
    always_comb begin
        if (sel_first) blk = {B0_FLAGS, nonce, len};
        else           blk = {CTR_FLAGS, nonce, ctr};
    end
endmodule

// File: rtl/ccm_bytemask.sv
module ccm_bytemask
    import ccm_pkg::*;
(
    input  logic [NB_W-1:0]  nbytes,
    output logic [BLK_W-1:0] mask
);
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        localparam logic [NB_W-1:0] IDX = NB_W'(i);
        assign mask[BLK_W-1-8*i -: 8] = (IDX < nbytes) ? 8'hFF : 8'h00;
    end
endmodule

// File: rtl/ccm_engine.sv
module ccm_engine
    import ccm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_valid,
    output logic              start_ready,
    input  logic [PN_W-1:0]   pkt_num,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [LEN_W-1:0]  pay_len,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BLK_W-1:0]  in_data,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BLK_W-1:0]  out_data,
    output logic [NB_W-1:0]   out_bytes,
    output logic              out_last,
    output logic              aes_req_valid,
    input  logic              aes_req_ready,
    output logic [BLK_W-1:0]  aes_req_data,
    input  logic              aes_rsp_valid,
    input  logic [BLK_W-1:0]  aes_rsp_data
);
    ctl_state_t        st_q;
    phase_t            ph_q;
    nonce_t            nonce_q;
    logic [LEN_W-1:0]  len_q;
    logic [CNT_W-1:0]  ctr_q;
    logic [BLK_W-1:0]  mac_q;
    logic [BLK_W-1:0]  blk_q;
    logic              last_q;
    logic [BLK_W-1:0]  obuf_q;
    logic [NB_W-1:0]   obytes_q;

    logic [NB_W-1:0]   tail;
    logic [NB_W-1:0]   in_nb;
    logic [NB_W-1:0]   out_nb;
    logic [BLK_W-1:0]  in_mask;
    logic [BLK_W-1:0]  out_mask;
    logic [BLK_W-1:0]  fmt_blk;
    logic [CNT_W-1:0]  ctr_sel;
    logic              sel_first;

    assign tail      = tail_bytes(len_q);
    assign in_nb     = in_last ? tail : NB_W'(NBYTES);
    assign out_nb    = last_q  ? tail : NB_W'(NBYTES);
    assign sel_first = (st_q == ST_MAC_FIRST);
    assign ctr_sel   = (st_q == ST_CTR_MIC) ? '0 : ctr_q;

    ccm_bytemask u_in_mask  (.nbytes(in_nb),  .mask(in_mask));
    ccm_bytemask u_out_mask (.nbytes(out_nb), .mask(out_mask));

    ccm_blkgen u_blkgen (
        .nonce     (nonce_q),
        .len       (len_q),
        .ctr       (ctr_sel),
        .sel_first (sel_first),
        .blk       (fmt_blk)
    );

    assign start_ready   = (st_q == ST_IDLE);
    assign in_ready      = (st_q == ST_MAC_DATA) && (ph_q == PH_IN);
    assign aes_req_valid = (st_q != ST_IDLE) && (st_q != ST_DONE) && (ph_q == PH_REQ);
    assign out_valid     = (ph_q == PH_OUT);
    assign out_data      = obuf_q;
    assign out_bytes     = obytes_q;
    assign out_last      = (st_q == ST_DONE);

    always_comb begin
        if (st_q == ST_MAC_DATA) aes_req_data = mac_q ^ blk_q;
        else                     aes_req_data = fmt_blk;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            ph_q     <= PH_IN;
            nonce_q  <= '0;
            len_q    <= '0;
            ctr_q    <= '0;
            mac_q    <= '0;
            blk_q    <= '0;
            last_q   <= 1'b0;
            obuf_q   <= '0;
            obytes_q <= '0;
        end else if (st_q == ST_IDLE) begin
            if (start_valid) begin
                nonce_q <= '{prio: 8'h00, addr: src_addr, pn: pkt_num};
                len_q   <= pay_len;
                ctr_q   <= CNT_W'(1);
                mac_q   <= '0;
                last_q  <= 1'b0;
                st_q    <= ST_MAC_FIRST;
                ph_q    <= PH_REQ;
            end
        end else begin
            case (ph_q)
                PH_IN: if (in_valid && in_ready) begin
                    blk_q  <= in_data & in_mask;
                    last_q <= in_last;
                    ph_q   <= PH_REQ;
                end
                PH_REQ: if (aes_req_valid && aes_req_ready) begin
                    ph_q <= PH_WAIT;
                end
                PH_WAIT: if (aes_rsp_valid) begin
                    case (st_q)
                        ST_MAC_FIRST: begin
                            mac_q <= aes_rsp_data;
                            if (len_q == '0) begin
                                st_q <= ST_CTR_MIC;
                                ph_q <= PH_REQ;
                            end else begin
                                st_q <= ST_MAC_DATA;
                                ph_q <= PH_IN;
                            end
                        end
                        ST_MAC_DATA: begin
                            mac_q <= aes_rsp_data;
                            st_q  <= ST_CTR_DATA;
                            ph_q  <= PH_REQ;
                        end
                        ST_CTR_DATA: begin
                            obuf_q   <= (blk_q ^ aes_rsp_data) & out_mask;
                            obytes_q <= out_nb;
                            ph_q     <= PH_OUT;
                        end
                        ST_CTR_MIC: begin
                            obuf_q   <= {mac_q[BLK_W-1 -: MIC_W] ^ aes_rsp_data[BLK_W-1 -: MIC_W],
                                         {(BLK_W-MIC_W){1'b0}}};
                            obytes_q <= NB_W'(MIC_BYTES);
                            st_q     <= ST_DONE;
                            ph_q     <= PH_OUT;
                        end
                        default: ;
                    endcase
                end
                PH_OUT: if (out_ready) begin
                    if (st_q == ST_DONE) begin
                        st_q <= ST_IDLE;
                        ph_q <= PH_IN;
                    end else begin
                        ctr_q <= ctr_q + CNT_W'(1);
                        if (last_q) begin
                            st_q <= ST_CTR_MIC;
                            ph_q <= PH_REQ;
                        end else begin
                            st_q <= ST_MAC_DATA;
                            ph_q <= PH_IN;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (aes_req_valid && !aes_req_ready) |=> (aes_req_valid && $stable(aes_req_data)));

    p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_bytes)));

    p_one_outstanding_r3: assert property (@(posedge clk) disable iff (rst)
        aes_rsp_valid |-> !aes_req_valid);

    p_mic_width_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last) |-> (out_bytes == NB_W'(MIC_BYTES) && out_data[BLK_W-MIC_W-1:0] == '0));

    p_bytes_range_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_bytes != '0 && out_bytes <= NB_W'(NBYTES)));

    p_first_block_r2: assert property (@(posedge clk) disable iff (rst)
        (start_valid && start_ready) |=>
            (aes_req_valid && aes_req_data[BLK_W-1 -: 8] == B0_FLAGS
             && aes_req_data[LEN_W-1:0] == $past(pay_len)));
endmodule

// File: tb/test_ccm_engine.sv
module test_ccm_engine;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_valid = 1'b0;
    logic         start_ready;
    logic [47:0]  pkt_num = '0;
    logic [47:0]  src_addr = '0;
    logic [15:0]  pay_len = '0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_data = '0;
    logic         in_last = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [127:0] out_data;
    logic [4:0]   out_bytes;
    logic         out_last;
    logic         aes_req_valid;
    logic         aes_req_ready = 1'b0;
    logic [127:0] aes_req_data;
    logic         aes_rsp_valid = 1'b0;
    logic [127:0] aes_rsp_data = '0;

    always #5 clk = ~clk;

    ccm_engine i_ccm_engine (
        .clk(clk), .rst(rst),
        .start_valid(start_valid), .start_ready(start_ready),
        .pkt_num(pkt_num), .src_addr(src_addr), .pay_len(pay_len),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_bytes(out_bytes), .out_last(out_last),
        .aes_req_valid(aes_req_valid), .aes_req_ready(aes_req_ready),
        .aes_req_data(aes_req_data),
        .aes_rsp_valid(aes_rsp_valid), .aes_rsp_data(aes_rsp_data)
    );

    localparam logic [127:0] KEY = 128'h000102030405060708090a0b0c0d0e0f;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit req_stall = 0;
    bit out_stall = 0;
    bit in_gap    = 0;

    logic [127:0] req_log [32];
    int           nreq = 0;
    logic [127:0] obs_data  [16];
    logic [4:0]   obs_bytes [16];
    logic         obs_last  [16];
    int           nout = 0;
    int           nin  = 0;

    logic [127:0] pay      [8];
    logic [127:0] exp_req  [32];
    logic [127:0] exp_out  [16];
    logic [4:0]   exp_bytes[16];

    logic [7:0] sbox [256];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string rq, input logic [127:0] act,
                       input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [7:0] xt(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 8'h00;
        for (int i = 0; i < 8; i++) begin
            if (b[0]) p = p ^ a;
            a = xt(a);
            b = b >> 1;
        end
        return p;
    endfunction

    initial begin
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv;
            inv = 8'h00;
            for (int y = 1; y < 256; y++)
                if (gmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            sbox[x] = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                      ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
        end
    end

    function automatic logic [127:0] aes_enc(input logic [127:0] key, input logic [127:0] pt);
        logic [7:0]   s [16];
        logic [7:0]   t [16];
        logic [127:0] rk;
        logic [127:0] res;
        logic [31:0]  w;
        logic [7:0]   rc, a0, a1, a2, a3;
        rk = key;
        rc = 8'h01;
        for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ rk[127-8*i -: 8];
        for (int r = 1; r <= 10; r++) begin
            for (int i = 0; i < 16; i++) t[i] = sbox[s[i]];
            for (int c = 0; c < 4; c++)
                for (int rw = 0; rw < 4; rw++) s[c*4+rw] = t[((c+rw)%4)*4+rw];
            if (r < 10) begin
                for (int c = 0; c < 4; c++) begin
                    a0 = s[c*4]; a1 = s[c*4+1]; a2 = s[c*4+2]; a3 = s[c*4+3];
                    s[c*4]   = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
                    s[c*4+1] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
                    s[c*4+2] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
                    s[c*4+3] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
                end
            end
            w = rk[31:0];
            w = {w[23:0], w[31:24]};
            w = {sbox[w[31:24]], sbox[w[23:16]], sbox[w[15:8]], sbox[w[7:0]]} ^ {rc, 24'h0};
            rk[127:96] = rk[127:96] ^ w;
            rk[95:64]  = rk[95:64]  ^ rk[127:96];
            rk[63:32]  = rk[63:32]  ^ rk[95:64];
            rk[31:0]   = rk[31:0]   ^ rk[63:32];
            rc = xt(rc);
            for (int i = 0; i < 16; i++) s[i] = s[i] ^ rk[127-8*i -: 8];
        end
        for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
        return res;
    endfunction

    function automatic logic [127:0] bmask(input int nb);
        logic [127:0] m = '0;
        for (int i = 0; i < 16; i++) if (i < nb) m[127-8*i -: 8] = 8'hFF;
        return m;
    endfunction

    // Cipher core model: one result per accepted request, variable latency.
    initial begin
        bit           pend = 0;
        int           cnt  = 0;
        logic [127:0] res  = '0;
        forever begin
            @(negedge clk);
            aes_rsp_valid = 1'b0;
            if (pend) begin
                if (cnt == 0) begin
                    aes_rsp_valid = 1'b1;
                    aes_rsp_data  = res;
                    pend = 0;
                end else cnt--;
            end
            aes_req_ready = !(req_stall && (cyc % 3 != 0));
            #1;
            if (aes_req_valid && aes_req_ready) begin
                if (nreq < 32) req_log[nreq] = aes_req_data;
                nreq++;
                res  = aes_enc(KEY, aes_req_data);
                pend = 1;
                cnt  = nreq % 3;
            end
        end
    end

    // Output monitor, including the hold-under-stall check (R8).
    initial begin
        bit           prev_stall = 0;
        logic [127:0] prev_data  = '0;
        forever begin
            @(negedge clk);
            out_ready = !(out_stall && (cyc % 3 != 0));
            #1;
            if (prev_stall)
                chk(out_valid && out_data == prev_data, "R8 output held under stall",
                    out_data, prev_data);
            if (out_valid && out_ready) begin
                if (nout < 16) begin
                    obs_data[nout]  = out_data;
                    obs_bytes[nout] = out_bytes;
                    obs_last[nout]  = out_last;
                end
                nout++;
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL R9 watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    task automatic run_pkt(input logic [47:0] pn, input logic [47:0] sa,
                           input int len, input int seed);
        int           n;
        int           tl;
        logic [127:0] mac, pblk, ks, b0, cb;
        n  = (len + 15) / 16;
        tl = (len % 16 == 0) ? 16 : len % 16;
        for (int k = 0; k < n; k++)
            pay[k] = {32'h01234567 + 32'(k) * 32'h11111111 + 32'(seed), 32'h89abcdef ^ 32'(seed),
                      32'hdeadbeef + 32'(k), 32'h0badf00d ^ (32'(seed) << k)};
        b0 = {8'h19, 8'h00, sa, pn, 16'(len)};
        exp_req[0] = b0;
        mac = aes_enc(KEY, b0);
        for (int k = 1; k <= n; k++) begin
            pblk = pay[k-1] & bmask((k == n) ? tl : 16);
            exp_req[2*k-1] = mac ^ pblk;
            mac = aes_enc(KEY, mac ^ pblk);
            cb = {8'h01, 8'h00, sa, pn, 16'(k)};
            exp_req[2*k] = cb;
            ks = aes_enc(KEY, cb);
            exp_out[k-1]   = (pblk ^ ks) & bmask((k == n) ? tl : 16);
            exp_bytes[k-1] = 5'((k == n) ? tl : 16);
        end
        cb = {8'h01, 8'h00, sa, pn, 16'h0000};
        exp_req[2*n+1] = cb;
        ks = aes_enc(KEY, cb);
        exp_out[n]   = {mac[127:64] ^ ks[127:64], 64'h0};
        exp_bytes[n] = 5'd8;

        nreq = 0; nout = 0; nin = 0;
        @(negedge clk);
        start_valid = 1'b1; pkt_num = pn; src_addr = sa; pay_len = 16'(len);
        #1;
        while (!start_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        start_valid = 1'b0;
        #1;
        chk(!start_ready, "R9 busy after start", 128'(start_ready), 128'(0));

        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = pay[k]; in_last = (k == n - 1);
            #1;
            while (!in_ready) begin @(negedge clk); #1; end
            nin++;
            @(negedge clk);
            in_valid = 1'b0; in_last = 1'b0;
            if (in_gap) repeat (2) @(negedge clk);
        end
        while (nout < n + 1) @(negedge clk);
        repeat (3) @(negedge clk);
        #1;

        chk(nreq == 2 * n + 2, "R3 core request count", 128'(nreq), 128'(2 * n + 2));
        chk(nout == n + 1, "R9 output beat count", 128'(nout), 128'(n + 1));
        chk(nin == n, "R9 input block count", 128'(nin), 128'(n));
        chk(start_ready, "R9 idle after MIC", 128'(start_ready), 128'(1));
        if (nreq == 2 * n + 2 && nout == n + 1) begin
            chk(req_log[0] == exp_req[0], "R2 first MAC block", req_log[0], exp_req[0]);
            for (int k = 1; k <= n; k++) begin
                chk(req_log[2*k-1] == exp_req[2*k-1], "R3 chained MAC request",
                    req_log[2*k-1], exp_req[2*k-1]);
                chk(req_log[2*k] == exp_req[2*k], "R4 payload counter block",
                    req_log[2*k], exp_req[2*k]);
                chk(obs_data[k-1] == exp_out[k-1], "R5 ciphertext", obs_data[k-1], exp_out[k-1]);
                chk(obs_bytes[k-1] == exp_bytes[k-1], "R5 valid byte count",
                    128'(obs_bytes[k-1]), 128'(exp_bytes[k-1]));
                chk(!obs_last[k-1], "R6 last flag only on MIC", 128'(obs_last[k-1]), 128'(0));
            end
            chk(req_log[2*n+1] == exp_req[2*n+1], "R4 counter zero block",
                req_log[2*n+1], exp_req[2*n+1]);
            chk(obs_data[n] == exp_out[n], "R6 encrypted MIC", obs_data[n], exp_out[n]);
            chk(obs_bytes[n] == 5'd8, "R6 MIC byte count", 128'(obs_bytes[n]), 128'(8));
            chk(obs_last[n], "R6 MIC last flag", 128'(obs_last[n]), 128'(1));
        end
    endtask

    task automatic test_reset_state();
        #1;
        chk(start_ready == 1'b1, "R1 start_ready after reset", 128'(start_ready), 128'(1));
        chk(!out_valid, "R1 out_valid after reset", 128'(out_valid), 128'(0));
        chk(!in_ready, "R1 in_ready after reset", 128'(in_ready), 128'(0));
        chk(!aes_req_valid, "R1 aes_req_valid after reset", 128'(aes_req_valid), 128'(0));
    endtask

    task automatic test_two_full_blocks();
        req_stall = 0; out_stall = 0; in_gap = 0;
        run_pkt(48'h0000_0000_0001, 48'h0a1b_2c3d_4e5f, 32, 3);
    endtask

    task automatic test_partial_tail();
        req_stall = 0; out_stall = 1; in_gap = 1;
        run_pkt(48'h1234_5678_9abc, 48'hfeed_face_cafe, 37, 11);
    endtask

    task automatic test_empty_payload();
        req_stall = 0; out_stall = 0; in_gap = 0;
        run_pkt(48'h0000_00ff_0000, 48'h0102_0304_0506, 0, 5);
        chk(nin == 0, "R7 no input taken for empty payload", 128'(nin), 128'(0));
        chk(nreq == 2, "R7 two requests for empty payload", 128'(nreq), 128'(2));
    endtask

    task automatic test_single_byte();
        req_stall = 1; out_stall = 0; in_gap = 0;
        run_pkt(48'hffff_ffff_fffe, 48'h7777_8888_9999, 1, 23);
    endtask

    task automatic test_full_block_stalled();
        req_stall = 1; out_stall = 1; in_gap = 1;
        run_pkt(48'h0000_1000_0042, 48'h5555_aaaa_5555, 16, 42);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        test_reset_state();
        test_two_full_blocks();
        test_partial_tail();
        test_empty_payload();
        test_single_byte();
        test_full_block_stalled();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule